// File: doc/BRIEF.md
# Translation Buffer Maintenance Register Port

This block is the register front end through which software maintains a small translation buffer. It holds an entry-select register, a process-ID register and a zone-protection register, and it owns the per-entry tag words, data words and 8-bit owner IDs (TIDs). Software selects an entry through the select register and then reads or writes the tag half or the data half of that entry. Writing an address to the search register makes the block walk the entries and report the first match back into the select register.

Whenever a cached copy of a translation may have gone stale, the block tells an attached translation cache with a one-cycle flush pulse. The pulse carries either an entry index or an "all" qualifier. Two configuration straps gate access. One sets the translation mode, and the other sets how much of the register set software may touch.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The block drops `req_ready` while a multi-cycle walk (a search, or a process-ID purge) is running, so the requester must hold its request until the walk ends. Read data comes back with `rsp_valid` one cycle after acceptance. Responses cannot be back-pressured.

Top module: `tlb_maint_port`

## Requirements
- R1: After reset, every register reads zero and every entry is invalid, so a search of any address misses and leaves the select register at 0x8000_0000. `rsp_valid` and `flush_valid` are low.
- R2: Register numbers are 0 select, 1 process ID, 2 zone, 3 search, 4 tag half and 5 data half. Numbers 6 and 7 read zero and ignore writes. A tag or data access goes to the entry given by the low log2(ENTRIES) bits of the select register. Bit 0 of the register number chooses data (1) or tag (0).
- R3: The tag word holds the page number in bits 31:10, a size code c in bits 9:7 for a page of 1024·4^c bytes, and a valid flag in bit 6. An address matches an entry when the two agree on every bit above the page size.
- R4: Reading the tag half returns the stored tag word and loads the process-ID register with that entry's TID, zero-extended.
- R5: Writing the tag half gives the entry a TID equal to process-ID bits 7:0, then stores the new word. If the old word was valid, the block emits one flush pulse carrying that index, with "all" low.
- R6: When the mode strap is below 2 or the access strap is 0, every read returns zero, every write has no effect, and no flush is issued.
- R7: Reads of the process-ID, zone, tag and data registers return zero unless bit 0 of the access strap is set. A tag read blocked this way leaves the process-ID register unchanged. The select register stays readable.
- R8: Writes to the zone, process-ID and search registers are ignored unless the access strap is 2 or 3.
- R9: A zone write that changes the stored value emits one flush pulse with "all" high. Writing the same value emits nothing.
- R10: A process-ID write that changes the value emits a flush pulse for each valid entry whose TID is non-zero and equal to bits 7:0 of the old value, in ascending index order. Writing the same value starts no walk.
- R11: A search looks up bits 31:10 of the written value. An entry qualifies if it is valid, its TID is zero or equal to process-ID bits 7:0, and it matches per R3. On a hit, the select register becomes the lowest qualifying index. On a miss, only bit 31 is set and the other bits are kept.
- R12: `req_ready` is low while a walk runs. A search that hits entry j holds it low for j+1 cycles. A miss or a purge holds it low for ENTRIES cycles. A read yields `rsp_valid` exactly one cycle after acceptance, and a write yields none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Translation mode strap |
| cfg_access | input | 2 | Register access level strap |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 3 | Register number |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| flush_valid | output | 1 | One-cycle flush request |
| flush_all | output | 1 | Flush request covers the whole cache |
| flush_idx | output | 8 | Entry index of a single flush |

## Verification
The bench targets the following corner cases, and each one shows up at the ports when the design gets it wrong:
- **Page size.** Searches probe the first byte, the last byte and the first byte past every page size. A wrong size mask would hit one page too far or miss a page's tail.
- **Global entries and stale select bits.** Searches run under several process IDs, and the select register is preset with a pattern before each one. A design that ignored global entries would report a wrong index. One that cleared the select register on a miss would return a wrong word.
- **Purge walk.** The bench checks the exact sequence of purge pulses and the exact stall length of every walk. Purging by the new ID, or stopping a search late, shows up as a wrong index list or a wrong stall count.
- **Straps.** Every pairing of the two straps is swept. Each blocked read or write is checked through a later privileged read-back.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;

  localparam int WORD_W    = 32;
  localparam int TID_W     = 8;
  localparam int REGSEL_W  = 3;
  localparam int FLIDX_W   = 8;
  localparam int VALID_POS = 6;
  localparam int SIZE_LSB  = 7;
  localparam int SIZE_W    = 3;
  localparam int MISS_POS  = 31;
  localparam logic [WORD_W-1:0] PAGE_NUM_MASK = 32'hFFFF_FC00;
  localparam logic [WORD_W-1:0] MIN_PAGE_BYTES = 32'd1024;

  typedef enum logic [REGSEL_W-1:0] {
    RS_SELECT = 3'd0,
    RS_PROC   = 3'd1,
    RS_ZONE   = 3'd2,
    RS_SEARCH = 3'd3,
    RS_TAG    = 3'd4,
    RS_DATA   = 3'd5,
    RS_SPARE6 = 3'd6,
    RS_SPARE7 = 3'd7
  } regsel_e;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_SEARCH,
    WK_PURGE
  } walk_e;

  // Mask keeping the address bits above the page selected by a size code.
  function automatic logic [WORD_W-1:0] page_keep_mask(input logic [SIZE_W-1:0] code);
    logic [WORD_W-1:0] bytes;
    bytes = MIN_PAGE_BYTES << {code, 1'b0};
    return ~(bytes - 32'd1);
  endfunction

  // Entry qualifies for a lookup: valid, page number agrees, owner allowed.
  function automatic logic entry_matches(input logic [WORD_W-1:0] tag,
                                         input logic [TID_W-1:0]  tid,
                                         input logic [WORD_W-1:0] va,
                                         input logic [TID_W-1:0]  pid);
    logic [WORD_W-1:0] keep;
    keep = page_keep_mask(tag[SIZE_LSB +: SIZE_W]);
    return tag[VALID_POS]
        && (((va & PAGE_NUM_MASK) & keep) == ((tag & PAGE_NUM_MASK) & keep))
        && ((tid == '0) || (tid == pid));
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_maint_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_tag,
  input  logic              we_data,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [TID_W-1:0]  wtid,
  input  logic [IDX_W-1:0]  raddr_a,
  output logic [WORD_W-1:0] tag_a,
  output logic [WORD_W-1:0] data_a,
  output logic [TID_W-1:0]  tid_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [WORD_W-1:0] tag_b,
  output logic [TID_W-1:0]  tid_b
);

  logic [WORD_W-1:0] tag_q  [ENTRIES];
  logic [WORD_W-1:0] data_q [ENTRIES];
  logic [TID_W-1:0]  tid_q  [ENTRIES];

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tag_q[e]  <= '0;
          data_q[e] <= '0;
          tid_q[e]  <= '0;
        end else begin
          if (we_tag && (waddr == IDX_W'(e))) begin
            tag_q[e] <= wdata;
            tid_q[e] <= wtid;
          end
          if (we_data && (waddr == IDX_W'(e))) begin
            data_q[e] <= wdata;
          end
        end
      end
    end
  endgenerate

  assign tag_a  = tag_q[raddr_a];
  assign data_a = data_q[raddr_a];
  assign tid_a  = tid_q[raddr_a];
  assign tag_b  = tag_q[raddr_b];
  assign tid_b  = tid_q[raddr_b];

  // Store never sees both halves written in one cycle.
  AST_ONE_HALF_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_tag && we_data)); // R2

endmodule

// File: rtl/tlb_walk_engine.sv
module tlb_walk_engine
  import tlb_maint_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_search,
  input  logic              start_purge,
  input  logic [WORD_W-1:0] key_in,
  input  logic [TID_W-1:0]  cur_pid,
  output logic [IDX_W-1:0]  ptr,
  input  logic [WORD_W-1:0] ent_tag,
  input  logic [TID_W-1:0]  ent_tid,
  output logic              busy,
  output logic              hit_o,
  output logic              miss_o,
  output logic [IDX_W-1:0]  hit_idx,
  output logic              purge_o,
  output logic [IDX_W-1:0]  purge_idx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  walk_e             mode_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [WORD_W-1:0] key_q;
  logic              at_last;
  logic              srch_hit;
  logic              purge_hit;

  assign at_last   = (ptr_q == LAST_IDX);
  assign srch_hit  = (mode_q == WK_SEARCH) && entry_matches(ent_tag, ent_tid, key_q, cur_pid);
  assign purge_hit = (mode_q == WK_PURGE) && ent_tag[VALID_POS]
                  && (ent_tid != '0) && (ent_tid == key_q[TID_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WK_IDLE;
      ptr_q  <= '0;
      key_q  <= '0;
    end else if (start_search) begin
      mode_q <= WK_SEARCH;
      ptr_q  <= '0;
      key_q  <= key_in & PAGE_NUM_MASK;
    end else if (start_purge) begin
      mode_q <= WK_PURGE;
      ptr_q  <= '0;
      key_q  <= key_in;
    end else if (mode_q != WK_IDLE) begin
      ptr_q <= ptr_q + 1'b1;
      if (at_last || srch_hit) begin
        mode_q <= WK_IDLE;
      end
    end
  end

  assign ptr       = ptr_q;
  assign busy      = (mode_q != WK_IDLE);
  assign hit_o     = srch_hit;
  assign miss_o    = (mode_q == WK_SEARCH) && at_last && !srch_hit;
  assign hit_idx   = ptr_q;
  assign purge_o   = purge_hit;
  assign purge_idx = ptr_q;

  AST_START_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_search || start_purge) |-> (mode_q == WK_IDLE)); // R12
  AST_SEARCH_STOPS_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |=> !busy); // R11
  AST_PURGE_RUNS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode_q == WK_PURGE) && !at_last) |=> busy); // R10

endmodule

// File: rtl/tlb_maint_port.sv
module tlb_maint_port
  import tlb_maint_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_mode,
  input  logic [1:0]  cfg_access,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [2:0]  req_reg,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        flush_valid,
  output logic        flush_all,
  output logic [7:0]  flush_idx
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  regsel_e           rsel;
  logic              accept;
  logic              enabled;
  logic              rd_allowed;
  logic              wr_priv;
  logic [IDX_W-1:0]  sel;

  logic [WORD_W-1:0] sel_q;
  logic [WORD_W-1:0] pid_q;
  logic [WORD_W-1:0] zone_q;

  logic              wr_sel, wr_tag, wr_data, wr_pid, wr_zone, wr_srch;
  logic              rd_tag;
  logic              pid_change, zone_change, tag_flush;
  logic [WORD_W-1:0] rd_word;

  logic [WORD_W-1:0] tag_a, data_a, tag_b;
  logic [TID_W-1:0]  tid_a, tid_b;
  logic [IDX_W-1:0]  wk_ptr, wk_hit_idx, wk_purge_idx;
  logic              wk_busy, wk_hit, wk_miss, wk_purge;

  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;
  logic              fl_v_q, fl_all_q;
  logic [FLIDX_W-1:0] fl_idx_q;

  assign rsel       = regsel_e'(req_reg);
  assign req_ready  = !wk_busy;
  assign accept     = req_valid && req_ready;
  assign enabled    = (cfg_mode >= 2'd2) && (cfg_access != 2'd0);
  assign rd_allowed = enabled && cfg_access[0];
  assign wr_priv    = enabled && (cfg_access >= 2'd2);
  assign sel        = sel_q[IDX_W-1:0];

  always_comb begin
    wr_sel  = 1'b0;
    wr_tag  = 1'b0;
    wr_data = 1'b0;
    wr_pid  = 1'b0;
    wr_zone = 1'b0;
    wr_srch = 1'b0;
    rd_tag  = 1'b0;
    if (accept && req_write && enabled) begin
      unique case (rsel)
        RS_SELECT: wr_sel  = 1'b1;
        RS_TAG:    wr_tag  = 1'b1;
        RS_DATA:   wr_data = 1'b1;
        RS_PROC:   wr_pid  = wr_priv;
        RS_ZONE:   wr_zone = wr_priv;
        RS_SEARCH: wr_srch = wr_priv;
        default:   ;
      endcase
    end
    if (accept && !req_write && rd_allowed && (rsel == RS_TAG)) begin
      rd_tag = 1'b1;
    end
  end

  assign pid_change  = wr_pid && (req_wdata != pid_q);
  assign zone_change = wr_zone && (req_wdata != zone_q);
  assign tag_flush   = wr_tag && tag_a[VALID_POS];

  always_comb begin
    rd_word = '0;
    if (enabled) begin
      unique case (rsel)
        RS_SELECT: rd_word = sel_q;
        RS_PROC:   rd_word = rd_allowed ? pid_q : '0;
        RS_ZONE:   rd_word = rd_allowed ? zone_q : '0;
        RS_TAG:    rd_word = rd_allowed ? tag_a : '0;
        RS_DATA:   rd_word = rd_allowed ? data_a : '0;
        default:   rd_word = '0;
      endcase
    end
  end

  tlb_entry_store #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_tag  (wr_tag),
    .we_data (wr_data),
    .waddr   (sel),
    .wdata   (req_wdata),
    .wtid    (pid_q[TID_W-1:0]),
    .raddr_a (sel),
    .tag_a   (tag_a),
    .data_a  (data_a),
    .tid_a   (tid_a),
    .raddr_b (wk_ptr),
    .tag_b   (tag_b),
    .tid_b   (tid_b)
  );

  tlb_walk_engine #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_search (wr_srch),
    .start_purge  (pid_change),
    .key_in       (wr_srch ? req_wdata : pid_q),
    .cur_pid      (pid_q[TID_W-1:0]),
    .ptr          (wk_ptr),
    .ent_tag      (tag_b),
    .ent_tid      (tid_b),
    .busy         (wk_busy),
    .hit_o        (wk_hit),
    .miss_o       (wk_miss),
    .hit_idx      (wk_hit_idx),
    .purge_o      (wk_purge),
    .purge_idx    (wk_purge_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      pid_q  <= '0;
      zone_q <= '0;
    end else begin
      if (wr_sel) begin
        sel_q <= req_wdata;
      end else if (wk_hit) begin
        sel_q <= WORD_W'(wk_hit_idx);
      end else if (wk_miss) begin
        sel_q[MISS_POS] <= 1'b1;
      end
      if (pid_change) begin
        pid_q <= req_wdata;
      end else if (rd_tag) begin
        pid_q <= WORD_W'(tid_a);
      end
      if (wr_zone) begin
        zone_q <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      fl_v_q      <= 1'b0;
      fl_all_q    <= 1'b0;
      fl_idx_q    <= '0;
    end else begin
      rsp_valid_q <= accept && !req_write;
      rsp_data_q  <= (accept && !req_write) ? rd_word : '0;
      fl_v_q      <= tag_flush || zone_change || wk_purge;
      fl_all_q    <= zone_change;
      if (tag_flush) begin
        fl_idx_q <= FLIDX_W'(sel);
      end else if (wk_purge) begin
        fl_idx_q <= FLIDX_W'(wk_purge_idx);
      end else begin
        fl_idx_q <= '0;
      end
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_data    = rsp_data_q;
  assign flush_valid = fl_v_q;
  assign flush_all   = fl_all_q;
  assign flush_idx   = fl_idx_q;

  AST_READ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_write) |=> rsp_valid); // R12
  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !rsp_valid); // R12
  AST_OFF_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !enabled) |=> !flush_valid); // R6
  AST_ALL_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> flush_valid); // R9
  AST_SAME_ZONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_zone && (req_wdata == zone_q)) |=> !flush_valid); // R9
  AST_TAG_READ_LOADS_PID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tag |=> (pid_q == WORD_W'($past(tid_a)))); // R4
  AST_MISS_KEEPS_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wk_miss |=> (sel_q[MISS_POS] && (sel_q[MISS_POS-1:0] == $past(sel_q[MISS_POS-1:0])))); // R11
  AST_STALL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_srch || pid_change) |=> !req_ready); // R12

endmodule

// File: tb/sim_tlb_maint_port.sv
`timescale 1ns/1ps
module sim_tlb_maint_port;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd3;
  logic [1:0]  cfg_access = 2'd3;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_reg = 3'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        flush_valid;
  logic        flush_all;
  logic [7:0]  flush_idx;

  always #2 clk = ~clk;

  tlb_maint_port #(.ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_access(cfg_access),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_reg(req_reg), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .flush_valid(flush_valid), .flush_all(flush_all),
    .flush_idx(flush_idx)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // model state
  logic [31:0] m_sel, m_pid, m_zone;
  logic [31:0] m_tag [N];
  logic [31:0] m_data [N];
  logic [7:0]  m_tid [N];

  // flush log
  int          fl_cnt = 0;
  logic [8:0]  fl_log [64];
  int          e_cnt;
  logic [8:0]  e_log [64];

  always @(negedge clk) begin
    if (rst_n && flush_valid && fl_cnt < 64) begin
      fl_log[fl_cnt] = {flush_all, flush_idx};
      fl_cnt = fl_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit en_now();
    return (cfg_mode >= 2'd2) && (cfg_access != 2'd0);
  endfunction

  function automatic int m_search(input logic [31:0] va);
    for (int i = 0; i < N; i++) begin
      logic [31:0] keep;
      keep = ~((32'd1024 << (2 * m_tag[i][9:7])) - 32'd1);
      if (m_tag[i][6] && (((va & 32'hFFFF_FC00) & keep) == ((m_tag[i] & 32'hFFFF_FC00) & keep))
          && (m_tid[i] == 8'd0 || m_tid[i] == m_pid[7:0]))
        return i;
    end
    return -1;
  endfunction

  task automatic drive(input logic w, input logic [2:0] r, input logic [31:0] d,
                       output logic rv, output logic [31:0] rd, output int stall);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_reg = r; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    rv = rsp_valid; rd = rsp_data;
    stall = 0;
    while (!req_ready) begin stall++; @(negedge clk); end
    @(negedge clk);
  endtask

  task automatic check_flushes(input string req);
    bit ok;
    ok = (fl_cnt == e_cnt);
    for (int i = 0; i < e_cnt && ok; i++) ok = (fl_log[i] == e_log[i]);
    chk(ok, req, "flush sequence (count)", fl_cnt, e_cnt);
  endtask

  task automatic op_write(input logic [2:0] r, input logic [31:0] v, input string req);
    logic rv; logic [31:0] rd; int stall, exp_stall, s, j;
    bit en, wp;
    en = en_now(); wp = en && (cfg_access >= 2'd2);
    s = int'(m_sel[2:0]);
    e_cnt = 0; exp_stall = 0;
    if (en) begin
      case (r)
        3'd0: m_sel = v;
        3'd4: begin
          if (m_tag[s][6]) begin e_log[e_cnt] = {1'b0, 8'(s)}; e_cnt++; end
          m_tid[s] = m_pid[7:0]; m_tag[s] = v;
        end
        3'd5: m_data[s] = v;
        3'd2: if (wp) begin
          if (v != m_zone) begin e_log[e_cnt] = 9'h100; e_cnt++; end
          m_zone = v;
        end
        3'd1: if (wp && v != m_pid) begin
          for (int i = 0; i < N; i++)
            if (m_tag[i][6] && m_tid[i] != 8'd0 && m_tid[i] == m_pid[7:0]) begin
              e_log[e_cnt] = {1'b0, 8'(i)}; e_cnt++;
            end
          m_pid = v; exp_stall = N;
        end
        3'd3: if (wp) begin
          j = m_search(v);
          if (j >= 0) begin m_sel = 32'(j); exp_stall = j + 1; end
          else begin m_sel[31] = 1'b1; exp_stall = N; end
        end
        default: ;
      endcase
    end
    fl_cnt = 0;
    drive(1'b1, r, v, rv, rd, stall);
    chk(rv == 1'b0, "R12", "no response to write", 32'(rv), 32'd0);
    chk(stall == exp_stall, "R12", "ready-low cycles", stall, exp_stall);
    check_flushes(req);
  endtask

  task automatic op_read(input logic [2:0] r, input string req);
    logic rv; logic [31:0] rd, exp; int stall, s;
    bit en, ra;
    en = en_now(); ra = en && cfg_access[0];
    s = int'(m_sel[2:0]);
    exp = 32'd0;
    if (en) begin
      case (r)
        3'd0: exp = m_sel;
        3'd1: exp = ra ? m_pid : 32'd0;
        3'd2: exp = ra ? m_zone : 32'd0;
        3'd4: if (ra) begin exp = m_tag[s]; m_pid = {24'd0, m_tid[s]}; end
        3'd5: exp = ra ? m_data[s] : 32'd0;
        default: exp = 32'd0;
      endcase
    end
    e_cnt = 0; fl_cnt = 0;
    drive(1'b0, r, 32'd0, rv, rd, stall);
    chk(rv == 1'b1, "R12", "response one cycle after read", 32'(rv), 32'd1);
    chk(rd == exp, req, $sformatf("read reg %0d", r), rd, exp);
    check_flushes(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog expired: actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_sel = 0; m_pid = 0; m_zone = 0;
    for (int i = 0; i < N; i++) begin m_tag[i] = 0; m_data[i] = 0; m_tid[i] = 0; end
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && flush_valid == 0, "R1", "outputs quiet in reset",
        {30'd0, rsp_valid, flush_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
    for (int r = 0; r < 8; r++) op_read(3'(r), (r >= 6) ? "R2" : "R1");
    op_write(3'd3, 32'h0000_0000, "R1");
    op_read(3'd0, "R1");

    // fill every entry, one per page size
    for (int i = 0; i < N; i++) begin
      logic [7:0] tid;
      tid = (i % 3 == 0) ? 8'h00 : ((i % 2) ? 8'h21 : 8'h22);
      op_write(3'd0, 32'(i), "R2");
      op_write(3'd1, {24'd0, tid}, "R10");
      op_write(3'd5, 32'hA500_0000 | 32'(i * 17), "R2");
      op_write(3'd4, (32'(i + 1) << 24) | (32'(i) << 7) | 32'h40 | 32'(i), "R5");
    end
    for (int i = 0; i < N; i++) begin
      op_write(3'd0, 32'(i), "R2");
      op_read(3'd4, "R4");
      op_read(3'd1, "R4");
      op_read(3'd5, "R2");
    end

    // search sweep: all sizes, edges, several process IDs
    for (int p = 0; p < 4; p++) begin
      logic [31:0] pv;
      pv = (p == 0) ? 32'h21 : (p == 1) ? 32'h22 : (p == 2) ? 32'h0 : 32'h55;
      op_write(3'd1, pv, "R10");
      for (int i = 0; i < N; i++) begin
        logic [31:0] base, sz;
        base = 32'(i + 1) << 24;
        sz   = 32'd1024 << (2 * i);
        for (int k = 0; k < 3; k++) begin
          op_write(3'd0, 32'h0000_5A03, "R11");
          op_write(3'd3, (k == 0) ? base : (k == 1) ? base + sz - 1 : base + sz, "R3");
          op_read(3'd0, "R11");
        end
      end
    end

    // tag overwrite and invalidation
    op_write(3'd0, 32'd3, "R2");
    op_write(3'd1, 32'h77, "R5");
    op_write(3'd4, 32'h3300_0040, "R5");
    op_write(3'd1, 32'h12, "R10");
    op_read(3'd4, "R4");
    op_read(3'd1, "R5");
    op_write(3'd4, 32'h3300_0000, "R5");
    op_write(3'd4, 32'h3300_0000, "R5");

    // purge walks
    op_write(3'd1, 32'h21, "R10");
    op_write(3'd1, 32'h22, "R10");
    op_write(3'd1, 32'h22, "R10");
    op_write(3'd1, 32'h100, "R10");

    // zone register
    op_write(3'd2, 32'h0000_1234, "R9");
    op_read(3'd2, "R9");
    op_write(3'd2, 32'h0000_1234, "R9");
    op_write(3'd2, 32'h8000_0001, "R9");

    // strap sweep
    for (int md = 0; md < 4; md++) begin
      for (int ac = 0; ac < 4; ac++) begin
        int k;
        k = md * 4 + ac;
        @(negedge clk);
        cfg_mode = 2'(md); cfg_access = 2'(ac);
        op_read(3'd0, "R6");
        op_read(3'd1, "R7");
        op_read(3'd2, "R7");
        op_read(3'd4, "R7");
        op_read(3'd5, "R7");
        op_read(3'd3, "R6");
        op_write(3'd0, 32'(k % N), "R6");
        op_write(3'd5, 32'hD000_0000 + 32'(k), "R6");
        op_write(3'd2, 32'h100 + 32'(k), "R8");
        op_write(3'd1, (k % 2) ? 32'h21 : 32'h40 + 32'(k), "R8");
        op_write(3'd3, 32'h0200_0000, "R8");
        @(negedge clk);
        cfg_mode = 2'd3; cfg_access = 2'd3;
        op_read(3'd0, "R6");
        op_read(3'd1, "R8");
        op_read(3'd2, "R8");
        op_read(3'd5, "R6");
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule